// File: doc/BRIEF.md
# Delta-Modulated Constant-Coefficient Multiplier

This block scales a one-bit delta-modulated stream by a fixed fraction and returns the result as another one-bit delta-modulated stream. The product is never formed as a binary word. A P+1 bit accumulator acts as a digital delta-modulation encoder. On every enabled cycle it adds a biased increment K·d + 2^P, where d is the input step (+1 or −1) and K is a P-bit coefficient. The carry that leaves the top adder stage is the output step. The gain is K/2^P, which is always below one. The step height is 2^P.

The increment is built without a multiplier. Each coefficient bit is XNORed with the input bit. The top increment bit equals the input bit. The adder carry-in is the inverted input bit. Carries ripple upward from bit 0, so the carry out of any lower stage t is also a valid delta-modulated stream. The tap input selects that stage, which gives the alternative gain (Kx_t − 2^t)/2^t. Here Kx_t is (K + 2^P) reduced modulo 2^(t+1).

The stream clock is an enable pulse on the system clock. The block is used inside larger delta-modulated filters and mixers. Such designs need an exact weighting with an error of at most one output step.

Top module: `dmm_const_mult`

## Requirements
- R1: While rst_ni is low, dm_o is 0 and the accumulator holds 2^P. Both are loaded asynchronously.
- R2: The input bit encodes the step: logic 1 means +1 and logic 0 means −1. Each enabled cycle adds K·d + 2^P to the accumulator.
- R3: With tap_i = P, dm_o after an enabled edge is 1 exactly when the unwrapped sum reaches 2^(P+1). The accumulator then keeps the sum modulo 2^(P+1).
- R4: With tap_i = P, let B be the running sum of output steps and D the running sum of input steps, both counted as ±1 from reset. Then 2^P·B − K·D stays in the range (−2^P, 2^P]. This means the decoded product is within one step of (K/2^P)·D.
- R5: For tap_i = t < P, dm_o is the carry out of stage t. It follows an encoder with modulus 2^(t+1) whose increment is Kx_t for d = +1 and 2^(t+1) − Kx_t for d = −1. Its start value is 2^P modulo 2^(t+1). The quantity 2^t·B − (Kx_t − 2^t)·D stays in the range (u0_t − 2^(t+1), u0_t], where u0_t is that start value.
- R6: When en_i is low at a clock edge, dm_o and the accumulator keep their values, whatever dm_i is.
- R7: With K = 0 and tap_i = P, the output after reset alternates 1, 0, 1, 0, … for any input. This is the idle pattern that encodes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Stream clock enable, one pulse per sample |
| dm_i | input | 1 | Input step, 1 means +1 and 0 means −1 |
| coef_i | input | P | Coefficient K, gain K/2^P |
| tap_i | input | $clog2(P+1) | Carry stage that drives the output. P gives full gain; values above P act as P |
| dm_o | output | 1 | Registered output step |

## Verification
The case that is hardest to reach from the ports is the error bound at its extremes. The accumulator has to sit at the edge of its range while the output still meets the one-step limit. This happens only for particular runs of equal input bits combined with large or small coefficients. To reach it, the bench sweeps every coefficient and every tap. Each combination gets four input patterns: long runs of +1, long runs of −1, alternation, and a pseudo-random run with enable gaps. At every sample the bench checks the exact output bit and the integrated error bound, and it checks the hold behaviour during the gaps.

// File: rtl/dmm_pkg.sv
package dmm_pkg;
  // clamp a tap request to the highest carry stage
  function automatic int unsigned tap_clamp(int unsigned req, int unsigned top);
    return (req > top) ? top : req;
  endfunction
endpackage

// File: rtl/dmm_incr_gen.sv
module dmm_incr_gen #(
  parameter int P = 3
) (
  input  logic         dm_i,
  input  logic [P-1:0] coef_i,
  output logic [P:0]   incr_o,
  output logic         cin_o
);
  // +1: {1,K} + 0 = K + 2^P ; -1: {0,~K} + 1 = 2^P - K
  for (genvar i = 0; i < P; i++) begin : g_xnor
    assign incr_o[i] = ~(coef_i[i] ^ dm_i);
  end
  assign incr_o[P] = dm_i;
  assign cin_o     = ~dm_i;
endmodule

// File: rtl/dmm_ripple_add.sv
module dmm_ripple_add #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_o
);
  logic [W:0] c;
  assign c[0] = cin_i;
  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum_o[i]   = a_i[i] ^ b_i[i] ^ c[i];
    assign c[i+1]     = (a_i[i] & b_i[i]) | (c[i] & (a_i[i] ^ b_i[i]));
    assign carry_o[i] = c[i+1];
  end

  always_comb begin
    if (!$isunknown({a_i, b_i, cin_i}))
      p_adder_sum_r3: assert ({carry_o[W-1], sum_o} == ({1'b0, a_i} + {1'b0, b_i} + (W+1)'(cin_i)))
        else $error("ripple chain disagrees with arithmetic sum");
  end
endmodule

// File: rtl/dmm_tap_sel.sv
module dmm_tap_sel #(
  parameter int W  = 4,
  parameter int TW = 2
) (
  input  logic [W-1:0]  carry_i,
  input  logic [TW-1:0] tap_i,
  output logic          bit_o
);
  import dmm_pkg::*;
  always_comb begin
    bit_o = carry_i[tap_clamp(int'(tap_i), W - 1)];
  end
endmodule

// File: rtl/dmm_const_mult.sv
module dmm_const_mult #(
  parameter int P = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       en_i,
  input  logic                       dm_i,
  input  logic [P-1:0]               coef_i,
  input  logic [$clog2(P+1)-1:0]     tap_i,
  output logic                       dm_o
);
  localparam int W  = P + 1;
  localparam int TW = $clog2(P + 1);
  localparam logic [W-1:0] STEP = W'(1) << P;

  logic [W-1:0] acc_q, sum, carry, incr;
  logic         cin, out_d;

  dmm_incr_gen #(.P(P)) u_incr (
    .dm_i(dm_i), .coef_i(coef_i), .incr_o(incr), .cin_o(cin)
  );

  dmm_ripple_add #(.W(W)) u_add (
    .a_i(acc_q), .b_i(incr), .cin_i(cin), .sum_o(sum), .carry_o(carry)
  );

  dmm_tap_sel #(.W(W), .TW(TW)) u_tap (
    .carry_i(carry), .tap_i(tap_i), .bit_o(out_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= STEP;
      dm_o  <= 1'b0;
    end else if (en_i) begin
      acc_q <= sum;
      dm_o  <= out_d;
    end
  end

  // independent arithmetic view of the biased update
  logic [W:0] ref_sum;
  logic       full_tap;
  assign ref_sum  = {1'b0, acc_q} + (dm_i ? ({1'b0, STEP} + (W+1)'(coef_i))
                                          : ({1'b0, STEP} - (W+1)'(coef_i)));
  assign full_tap = (int'(tap_i) >= P);

  p_full_sum_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && full_tap |=> {dm_o, acc_q} == $past(ref_sum));

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(acc_q) && $stable(dm_o));

  p_neg_low_no_carry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !dm_i && full_tap && !acc_q[P] |=> !dm_o);

  p_pos_high_carry_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && dm_i && full_tap && acc_q[P] |=> dm_o);
endmodule

// File: tb/dmm_const_mult_tb.sv
`timescale 1ns/1ps
module dmm_const_mult_tb;
  localparam int P  = 3;
  localparam int TW = $clog2(P + 1);
  localparam int NS = 48;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          en_i = 1'b0;
  logic          dm_i = 1'b0;
  logic [P-1:0]  coef_i = '0;
  logic [TW-1:0] tap_i = '0;
  logic          dm_o;

  always #2.5 clk_i = ~clk_i;

  dmm_const_mult #(.P(P)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .dm_i(dm_i),
    .coef_i(coef_i), .tap_i(tap_i), .dm_o(dm_o)
  );

  int n_cmp = 0, n_bad = 0;
  int t_m, mod_m, kx_m, u_m, u0_m, gain_m, bsum, dsum;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg(int t, int k);
    @(negedge clk_i);
    rst_ni = 1'b0; en_i = 1'b0;
    tap_i = TW'(t); coef_i = P'(k);
    @(negedge clk_i);
    chk("R1 output low in reset", int'(dm_o), 0);
    rst_ni = 1'b1;
    t_m    = t;
    mod_m  = 1 << (t + 1);
    kx_m   = (k + (1 << P)) % mod_m;
    u_m    = (1 << P) % mod_m;
    u0_m   = u_m;
    gain_m = kx_m - (1 << t);
    bsum = 0; dsum = 0;
  endtask

  task automatic step(bit d, bit en);
    int  inc, s, v;
    bit  eb, prev;
    @(negedge clk_i);
    prev = dm_o; dm_i = d; en_i = en;
    @(posedge clk_i);
    #1;
    if (en) begin
      // R2: +1 adds the extended coefficient, -1 adds its complement to the stage modulus
      inc = d ? kx_m : mod_m - kx_m;
      s   = u_m + inc;
      eb  = (s >= mod_m);
      u_m = s % mod_m;
      chk((t_m == P) ? "R2 R3 output bit" : "R5 tap output bit", int'(dm_o), int'(eb));
      bsum += dm_o ? 1 : -1;
      dsum += d ? 1 : -1;
      v = u0_m - ((1 << t_m) * bsum - gain_m * dsum);
      chk((t_m == P) ? "R4 error bound" : "R5 tap error bound", int'(v >= 0 && v < mod_m), 1);
    end else begin
      chk("R6 hold without enable", int'(dm_o), int'(prev));
    end
    en_i = 1'b0;
  endtask

  function automatic bit pat_bit(int pat, int i);
    case (pat)
      0: return 1'b1;
      1: return 1'b0;
      2: return i[0];
      default: return lfsr[0];
    endcase
  endfunction

  initial begin
    for (int t = 0; t <= P; t++) begin
      for (int k = 0; k < (1 << P); k++) begin
        for (int pat = 0; pat < 4; pat++) begin
          cfg(t, k);
          for (int i = 0; i < NS; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(pat_bit(pat, i), !(pat == 3 && (i % 7) == 6));
          end
        end
      end
    end
    // R7: zero coefficient at full tap yields the idle pattern
    cfg(P, 0);
    for (int i = 0; i < 8; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], 1'b1);
      chk("R7 idle pattern", int'(dm_o), int'((i % 2) == 0));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule